// File: doc/BRIEF.md
# Control Endpoint Status and Control Register Pair

This block is the processor-facing register pair for the control endpoint of a USB controller that works as host or as peripheral. Software reaches it through a byte-wide port with separate read and write strobes and a select line that chooses the low or the high byte. The low byte holds the packet handshake flags. Software marks a transmit packet as loaded, and the packet engine reports when it has been sent. The packet engine reports an arriving packet, and software acknowledges it once the packet has been drained.

The high byte carries a flush command in both modes. In host mode it also carries a data toggle, which can only be loaded through a write-enable bit in the same write, and a level that tells the packet engine not to send PING tokens. A mode input chooses how the high byte is decoded. The block also keeps the read/write pointer of the endpoint packet FIFO, which a flush returns to zero. It raises a one-cycle interrupt pulse when a transmission completes or a packet arrives.

Top module: `ep0_ctl_regs`

## Requirements
- R1: After a synchronous reset, both flags, the toggle, the PING-disable level, the FIFO pointer, the interrupt and the read data are all 0.
- R2: Low byte bit 1 is the transmit-ready flag. A write of 1 sets it and a write of 0 leaves it unchanged. A packet-sent strobe clears it. If a software set and a packet-sent strobe come in the same cycle, the flag ends at 1.
- R3: Low byte bit 0 is the receive-ready flag. A packet-received strobe sets it. A low-byte write with bit 0 at 0 clears it, and a write with bit 0 at 1 leaves it unchanged. When a set and a clear (a write or a flush) come in the same cycle, the flag ends at 1.
- R4: When the interrupt enable is high, `irq` pulses high for exactly one cycle in the cycle after a packet-received strobe, and in the cycle after a packet-sent strobe that arrives while the transmit flag is set. A packet-sent strobe while the flag is clear gives no pulse, and neither event gives a pulse while the enable is low.
- R5: A high-byte write with bit 0 at 1 is a flush in either mode. It clears both flags and sets the FIFO pointer to 0. Bit 0 always reads as 0.
- R6: In host mode, a high-byte write with bit 2 at 1 loads bit 1 into the data toggle. A write with bit 2 at 0 leaves the toggle unchanged. Bit 2 always reads as 0.
- R7: A toggle-flip strobe from the packet engine inverts the toggle, except in a cycle that has a gated software write, where the written value is kept.
- R8: In host mode, every high-byte write loads bit 3 into the PING-disable level, which drives `ping_off` and reads back at high byte bit 3.
- R9: In peripheral mode, high-byte bits 7:1 read as 0, and writes to them change no state. In host mode, high-byte bits 7:4 read as 0, and low-byte bits 7:2 read as 0 in both modes.
- R10: A FIFO advance strobe increments the pointer, which wraps from depth-1 to 0. A flush in the same cycle wins and gives 0.
- R11: Reads are registered. `cpu_rdata` takes the selected byte in the cycle after `cpu_rd` and holds it until the next read. The high byte in host mode reads as {0000, ping, 0, toggle, 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 selects host decoding of the high byte, 0 selects peripheral |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_sel_hi | input | 1 | 0 addresses the low byte, 1 the high byte |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| irq_en | input | 1 | Interrupt enable |
| tx_sent | input | 1 | Packet engine: transmit packet completed |
| rx_arrived | input | 1 | Packet engine: packet received into the FIFO |
| tog_flip | input | 1 | Packet engine: invert the data toggle |
| fifo_adv | input | 1 | Advance the FIFO pointer by one |
| fifo_ptr | output | PTR_W | FIFO pointer |
| data_tog | output | 1 | Current data toggle |
| ping_off | output | 1 | PING-disable level for the packet engine |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A walked sequence of register writes, each followed by reads of both bytes, covers the gated toggle load with the enable bit both high and low. Reserved-bit patterns such as 0xF4 and 0xFC show that reserved positions neither store nor echo. The same sequence run in peripheral mode, followed by a host-mode read, shows that state written earlier survives writes that are ignored. Directed cases then drive strobes that coincide: a set and a clear of the receive flag, a flush with an arrival and a pointer advance, and a toggle flip with a gated write. These cases show which side wins. A packet-sent strobe on a clear flag, a disabled interrupt, and a run to the pointer wrap separate real interrupt and pointer behaviour from values that are merely stuck or off by one.

// File: rtl/ep0_ctl_pkg.sv
package ep0_ctl_pkg;
  localparam int unsigned REG_W     = 8;
  // low byte fields
  localparam int unsigned LO_RX     = 0;
  localparam int unsigned LO_TX     = 1;
  // high byte fields
  localparam int unsigned HI_FLUSH  = 0;
  localparam int unsigned HI_TOG    = 1;
  localparam int unsigned HI_TOG_WE = 2;
  localparam int unsigned HI_PING   = 3;

  typedef logic [REG_W-1:0] reg_byte_t;
endpackage

// File: rtl/ep0_ready_flags.sv
module ep0_ready_flags
  import ep0_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lo_wr,
  input  reg_byte_t wdata,
  input  logic      flush,
  input  logic      tx_sent,
  input  logic      rx_arrived,
  input  logic      irq_en,
  output logic      tx_rdy,
  output logic      rx_rdy,
  output logic      irq
);
  logic sw_set_tx;
  logic sw_clr_rx;

  assign sw_set_tx = lo_wr && wdata[LO_TX];
  assign sw_clr_rx = lo_wr && !wdata[LO_RX];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_rdy <= 1'b0;
      rx_rdy <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (sw_set_tx)                tx_rdy <= 1'b1;
      else if (tx_sent || flush)    tx_rdy <= 1'b0;

      if (rx_arrived)               rx_rdy <= 1'b1;
      else if (flush || sw_clr_rx)  rx_rdy <= 1'b0;

      irq <= irq_en && ((tx_sent && tx_rdy) || rx_arrived);
    end
  end

  // R3
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    rx_arrived |=> rx_rdy);

  // R2
  tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_sent && !lo_wr) |=> !tx_rdy);

  // R5
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && !rx_arrived) |=> (!tx_rdy && !rx_rdy));

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(rx_arrived)) |=> !irq);
endmodule

// File: rtl/ep0_host_ctl.sv
module ep0_host_ctl
  import ep0_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      host,
  input  logic      hi_wr,
  input  reg_byte_t wdata,
  input  logic      tog_flip,
  output logic      tog,
  output logic      ping_off
);
  logic host_wr;
  logic tog_load;

  assign host_wr  = hi_wr && host;
  assign tog_load = host_wr && wdata[HI_TOG_WE];

  always_ff @(posedge clk) begin
    if (rst) begin
      tog      <= 1'b0;
      ping_off <= 1'b0;
    end else begin
      if (tog_load)      tog <= wdata[HI_TOG];
      else if (tog_flip) tog <= ~tog;

      if (host_wr)       ping_off <= wdata[HI_PING];
    end
  end

  // R7
  tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (tog_flip && !tog_load) |=> (tog != $past(tog)));

  // R6
  tog_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !wdata[HI_TOG_WE] && !tog_flip) |=> $stable(tog));

  // R9
  periph_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!host && !tog_flip) |=> ($stable(tog) && $stable(ping_off)));
endmodule

// File: rtl/ep0_fifo_ptr.sv
module ep0_fifo_ptr #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_inc;

  generate
    if (POW2) begin : g_natural_wrap
      assign ptr_inc = ptr + 1'b1;
    end else begin : g_cmp_wrap
      assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || flush) ptr <= '0;
    else if (adv)     ptr <= ptr_inc;
  end

  // R10
  ptr_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ptr == '0));

  // R10
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
endmodule

// File: rtl/ep0_ctl_regs.sv
module ep0_ctl_regs
  import ep0_ctl_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned PTR_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_mode,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic             cpu_sel_hi,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  input  logic             irq_en,
  input  logic             tx_sent,
  input  logic             rx_arrived,
  input  logic             tog_flip,
  input  logic             fifo_adv,
  output logic [PTR_W-1:0] fifo_ptr,
  output logic             data_tog,
  output logic             ping_off,
  output logic             irq
);
  logic      lo_wr, hi_wr, flush;
  logic      tx_rdy, rx_rdy;
  reg_byte_t lo_view, hi_view;

  assign lo_wr = cpu_wr && !cpu_sel_hi;
  assign hi_wr = cpu_wr &&  cpu_sel_hi;
  assign flush = hi_wr && cpu_wdata[HI_FLUSH];

  ep0_ready_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .lo_wr      (lo_wr),
    .wdata      (cpu_wdata),
    .flush      (flush),
    .tx_sent    (tx_sent),
    .rx_arrived (rx_arrived),
    .irq_en     (irq_en),
    .tx_rdy     (tx_rdy),
    .rx_rdy     (rx_rdy),
    .irq        (irq)
  );

  ep0_host_ctl u_host (
    .clk      (clk),
    .rst      (rst),
    .host     (host_mode),
    .hi_wr    (hi_wr),
    .wdata    (cpu_wdata),
    .tog_flip (tog_flip),
    .tog      (data_tog),
    .ping_off (ping_off)
  );

  ep0_fifo_ptr #(.DEPTH(FIFO_DEPTH)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .adv   (fifo_adv),
    .ptr   (fifo_ptr)
  );

  always_comb begin
    lo_view         = '0;
    lo_view[LO_TX]  = tx_rdy;
    lo_view[LO_RX]  = rx_rdy;
    hi_view         = '0;
    if (host_mode) begin
      hi_view[HI_PING] = ping_off;
      hi_view[HI_TOG]  = data_tog;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= cpu_sel_hi ? hi_view : lo_view;
  end

  // R9
  periph_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_sel_hi && !host_mode) |=> (cpu_rdata == 8'h00));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));

  // R5
  flush_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_sel_hi) |=> !cpu_rdata[HI_FLUSH] && !cpu_rdata[HI_TOG_WE]);
endmodule

// File: tb/ep0_ctl_regs_bench.sv
module ep0_ctl_regs_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int PW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst;
  logic          host_mode, cpu_wr, cpu_rd, cpu_sel_hi;
  logic [7:0]    cpu_wdata, cpu_rdata;
  logic          irq_en, tx_sent, rx_arrived, tog_flip, fifo_adv;
  logic [PW-1:0] fifo_ptr;
  logic          data_tog, ping_off, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ep0_ctl_regs #(.FIFO_DEPTH(DEPTH)) u_ep0_ctl_regs (
    .clk(clk), .rst(rst), .host_mode(host_mode), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_sel_hi(cpu_sel_hi), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq_en(irq_en), .tx_sent(tx_sent),
    .rx_arrived(rx_arrived), .tog_flip(tog_flip), .fifo_adv(fifo_adv),
    .fifo_ptr(fifo_ptr), .data_tog(data_tog), .ping_off(ping_off), .irq(irq)
  );

  // vector: {host, sel_hi, wdata, expected low byte, expected high byte}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h02, 8'h02, 8'h00},  // R2 set tx
    {1'b1, 1'b1, 8'h02, 8'h02, 8'h00},  // R6 toggle without enable ignored
    {1'b1, 1'b1, 8'h06, 8'h02, 8'h02},  // R6 gated load 1
    {1'b1, 1'b1, 8'h08, 8'h02, 8'h0A},  // R8 ping on, toggle kept
    {1'b1, 1'b1, 8'hF4, 8'h02, 8'h00},  // R9 reserved ignored, R6 load 0
    {1'b1, 1'b1, 8'h0E, 8'h02, 8'h0A},  // R6 R8
    {1'b1, 1'b1, 8'h01, 8'h00, 8'h02},  // R5 flush, reads 0
    {1'b0, 1'b1, 8'h0E, 8'h00, 8'h00},  // R9 peripheral high byte
    {1'b0, 1'b0, 8'h02, 8'h02, 8'h00},  // R2 peripheral low byte
    {1'b1, 1'b1, 8'h08, 8'h02, 8'h0A},  // R9 earlier peripheral write left toggle
    {1'b1, 1'b0, 8'hFC, 8'h02, 8'h0A},  // R9 low reserved bits
    {1'b1, 1'b0, 8'h01, 8'h02, 8'h0A}   // R2 write 0 to tx has no effect
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic hi, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_sel_hi = hi; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0; cpu_wdata = 8'h00;
  endtask

  task automatic reg_rd(input logic hi, output logic [7:0] d);
    cpu_rd = 1'b1; cpu_sel_hi = hi;
    tick();
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    rst = 1'b1; host_mode = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b0;
    cpu_sel_hi = 1'b0; cpu_wdata = 8'h00; irq_en = 1'b1;
    tx_sent = 1'b0; rx_arrived = 1'b0; tog_flip = 1'b0; fifo_adv = 1'b0;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", cpu_rdata, 8'h00);
    chk("R1 outputs", {4'b0, data_tog, ping_off, irq, 1'b0}, 8'h00);
    chk("R1 ptr", 8'(fifo_ptr), 8'h00);
    reg_rd(1'b0, rd); chk("R1 low", rd, 8'h00);
    reg_rd(1'b1, rd); chk("R1 high", rd, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      host_mode = VEC[i][25];
      reg_wr(VEC[i][24], VEC[i][23:16]);
      reg_rd(1'b0, rd); chk($sformatf("R11 vec%0d low", i), rd, VEC[i][15:8]);
      reg_rd(1'b1, rd); chk($sformatf("R11 vec%0d high", i), rd, VEC[i][7:0]);
    end
    host_mode = 1'b1;
    chk("R8 ping_off port", {7'b0, ping_off}, 8'h01);

    // R4 tx completion raises irq and clears tx (R2)
    tx_sent = 1'b1; tick(); tx_sent = 1'b0;
    chk("R4 irq after tx", {7'b0, irq}, 8'h01);
    tick();
    chk("R4 irq one cycle", {7'b0, irq}, 8'h00);
    reg_rd(1'b0, rd); chk("R2 tx cleared", rd, 8'h00);

    // R4 no irq when tx flag already clear
    tx_sent = 1'b1; tick(); tx_sent = 1'b0;
    chk("R4 no irq tx clear", {7'b0, irq}, 8'h00);

    // R2 set and sent in same cycle
    tx_sent = 1'b1; reg_wr(1'b0, 8'h03); tx_sent = 1'b0;
    reg_rd(1'b0, rd); chk("R2 set beats sent", rd, 8'h02);
    tx_sent = 1'b1; tick(); tx_sent = 1'b0; tick();

    // R3 arrival sets rx, irq
    rx_arrived = 1'b1; tick(); rx_arrived = 1'b0;
    chk("R4 irq after rx", {7'b0, irq}, 8'h01);
    reg_rd(1'b0, rd); chk("R3 rx set", rd, 8'h01);

    // R3 set beats simultaneous clear; R4 disabled
    irq_en = 1'b0;
    rx_arrived = 1'b1; reg_wr(1'b0, 8'h00); rx_arrived = 1'b0;
    chk("R4 irq disabled", {7'b0, irq}, 8'h00);
    reg_rd(1'b0, rd); chk("R3 set beats clear", rd, 8'h01);
    irq_en = 1'b1;

    // R3 software clear
    reg_wr(1'b0, 8'h00);
    reg_rd(1'b0, rd); chk("R3 sw clear", rd, 8'h00);

    // R7 flip (toggle is 1, ping 1)
    tog_flip = 1'b1; tick(); tog_flip = 1'b0;
    reg_rd(1'b1, rd); chk("R7 flip", rd, 8'h08);

    // R7 gated write wins over flip; R8 port follows
    tog_flip = 1'b1; reg_wr(1'b1, 8'h06); tog_flip = 1'b0;
    reg_rd(1'b1, rd); chk("R7 write beats flip", rd, 8'h02);
    chk("R7 data_tog port", {7'b0, data_tog}, 8'h01);
    chk("R8 ping_off low", {7'b0, ping_off}, 8'h00);

    // R10 advance then flush with advance and arrival
    fifo_adv = 1'b1; repeat (5) tick(); fifo_adv = 1'b0;
    chk("R10 ptr 5", 8'(fifo_ptr), 8'h05);
    reg_wr(1'b0, 8'h02);
    fifo_adv = 1'b1; rx_arrived = 1'b1;
    reg_wr(1'b1, 8'h03);
    fifo_adv = 1'b0; rx_arrived = 1'b0;
    chk("R10 flush beats advance", 8'(fifo_ptr), 8'h00);
    reg_rd(1'b0, rd); chk("R5 R3 flush with arrival", rd, 8'h01);

    // R10 wrap
    fifo_adv = 1'b1; repeat (DEPTH - 1) tick();
    chk("R10 ptr last", 8'(fifo_ptr), 8'(DEPTH - 1));
    tick(); fifo_adv = 1'b0;
    chk("R10 ptr wrap", 8'(fifo_ptr), 8'h00);

    // R11 rdata holds without a read
    reg_rd(1'b1, rd);
    reg_wr(1'b1, 8'h0C); tick();
    chk("R11 rdata held", cpu_rdata, rd);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule